// File: doc/BRIEF.md
# Programmable-Logic Configuration Power-Up Sequencer

This block is a hardware state machine that carries a programmable-logic region through the steps before and after a configuration image is loaded. On a start request for a full load it puts every fabric interface into reset. It then walks the cross-domain isolation enables from their operating value to all-off and then to outbound-only. Next it drives the active-low program strobe through a three-phase handshake against the init status input, with a timeout on each wait. It then enables the processor-side configuration port. After the configuration-done input rises, it releases the port, opens isolation in both directions and removes the fabric resets.

For a partial reconfiguration the reset, isolation and program handshake are skipped: only the port is enabled, the done wait runs, and the port is released. An encrypted image is refused at once unless the secure-boot input is high. The moving of configuration data is outside this block. Every wait is bounded by a timer of `PRESC_DIV * TIMEOUT_TICKS` clock cycles. The run ends with exactly one single-cycle `okPulse` or `errPulse`.

Top module: `plcfg_sequencer`

## Requirements
- R1: After reset, fabricRst is 0x0, isoEn is 0xF, progB is 1, portSel, portMode and rateLow are 0, and okPulse and errPulse are 0.
- R2: On a full load, fabricRst becomes 0xF first. isoEn then becomes 0x0, and then 0xA (the outbound-only pattern). All of this happens before progB is first driven low.
- R3: The program handshake keeps progB high until initStat is seen high. It then drives progB low until initStat is seen low, then drives progB high again. portSel rises only after that second high phase has begun.
- R4: A wait on initStat or doneStat that gets no response ends the run with errPulse and errCode = 1 (timeout). This happens no earlier than PRESC_DIV*TIMEOUT_TICKS cycles after the start.
- R5: After the handshake (or directly, for a partial load), portSel and portMode are both 1. rateLow is 1 exactly when the run was started with encrypted set.
- R6: A start with encrypted=1 and secureBoot=0 gives errPulse with errCode = 2 in the second cycle after the start is sampled, and no control output changes.
- R7: After doneStat is seen high, portSel returns to 0, then isoEn becomes 0xF, then fabricRst becomes 0x0, and then okPulse fires with errCode 0.
- R8: When partialCfg is set at start, fabricRst, isoEn and progB keep their values for the whole run.
- R9: okPulse and errPulse each last one cycle, are never high together, and exactly one of them fires per accepted start.
- R10: A start request arriving while a run is in progress is ignored: it neither restarts the sequence nor produces a second result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled only while idle |
| partialCfg | input | 1 | Partial reconfiguration: skip reset, isolation and program steps |
| encrypted | input | 1 | Image is encrypted: requires secure boot, selects reduced rate |
| secureBoot | input | 1 | Secure-boot status from the system |
| initStat | input | 1 | Fabric init status |
| doneStat | input | 1 | Configuration-done status |
| fabricRst | output | 4 | Fabric interface reset levels (all-ones = held in reset) |
| isoEn | output | 4 | Cross-domain isolation enables (0x0 none, 0xA outbound, 0xF both) |
| progB | output | 1 | Active-low program strobe |
| portSel | output | 1 | Processor-side configuration port selected for programming |
| portMode | output | 1 | Configuration port enabled |
| rateLow | output | 1 | Reduced transfer rate for on-the-fly decryption |
| okPulse | output | 1 | Single-cycle successful completion |
| errPulse | output | 1 | Single-cycle failure |
| errCode | output | 2 | Cause of the last failure: 1 timeout, 2 insecure; 0 after success |

## Verification
The embedded properties watch the local causal links on every cycle. The program strobe may only fall after init was seen high, and only while resets are on and isolation is outbound. The port may only be released after done was seen. The result pulses stay exclusive and one cycle wide, and the timer stays within its bound. The overall stage ordering needs the bench's scenario runs to show it, as do the exact timeout window, the untouched outputs of a partial load, the refused insecure start and the ignored mid-run start, because each of these spans a whole run.

// File: rtl/plcfg_pkg.sv
package plcfg_pkg;

  localparam int RST_W = 4;
  localparam int ISO_W = 4;

  localparam logic [RST_W-1:0] RST_ALL    = '1;
  localparam logic [RST_W-1:0] RST_NONE   = '0;
  localparam logic [ISO_W-1:0] ISO_NONE   = '0;
  localparam logic [ISO_W-1:0] ISO_OUTB   = {(ISO_W/2){2'b10}};
  localparam logic [ISO_W-1:0] ISO_BOTH   = '1;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_TIMEOUT  = 2'd1,
    ERR_INSECURE = 2'd2
  } err_code_e;

  typedef enum logic [4:0] {
    S_IDLE, S_RST_ON, S_ISO_OFF, S_ISO_OUT,
    S_PROG_SET1, S_WAIT_HI1, S_PROG_CLR, S_WAIT_LO,
    S_PROG_SET2, S_WAIT_HI2, S_PORT_ON, S_WAIT_DONE,
    S_PORT_OFF, S_ISO_OPEN, S_RST_OFF, S_FINISH, S_FAIL
  } seq_state_e;

  typedef struct packed {
    logic      rstAll;
    logic      rstNone;
    logic      isoOff;
    logic      isoOut;
    logic      isoOpen;
    logic      progSet;
    logic      progClr;
    logic      portOn;
    logic      portOff;
    logic      rateLow;
    logic      tmrClr;
    logic      okStb;
    logic      errStb;
    err_code_e errCode;
  } seq_strobe_t;

endpackage

// File: rtl/plcfg_ctrl.sv
module plcfg_ctrl
  import plcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        partialCfg,
  input  logic        encrypted,
  input  logic        secureBoot,
  input  logic        initStat,
  input  logic        doneStat,
  input  logic        timeoutHit,
  output seq_strobe_t stb,
  output logic        idle
);

  seq_state_e state, nxt;
  logic       partQ, encQ;
  err_code_e  errQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      partQ <= 1'b0;
      encQ  <= 1'b0;
      errQ  <= ERR_NONE;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        partQ <= partialCfg;
        encQ  <= encrypted;
        errQ  <= (encrypted && !secureBoot) ? ERR_INSECURE : ERR_TIMEOUT;
      end
    end
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.errCode = errQ;
    stb.rateLow = encQ;
    stb.tmrClr  = 1'b1;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          if (encrypted && !secureBoot) nxt = S_FAIL;
          else if (partialCfg)          nxt = S_PORT_ON;
          else                          nxt = S_RST_ON;
        end
      end
      S_RST_ON:    begin stb.rstAll  = 1'b1; nxt = S_ISO_OFF;   end
      S_ISO_OFF:   begin stb.isoOff  = 1'b1; nxt = S_ISO_OUT;   end
      S_ISO_OUT:   begin stb.isoOut  = 1'b1; nxt = S_PROG_SET1; end
      S_PROG_SET1: begin stb.progSet = 1'b1; nxt = S_WAIT_HI1;  end
      S_WAIT_HI1: begin
        stb.tmrClr = 1'b0;
        if (initStat)        nxt = S_PROG_CLR;
        else if (timeoutHit) nxt = S_FAIL;
      end
      S_PROG_CLR:  begin stb.progClr = 1'b1; nxt = S_WAIT_LO;   end
      S_WAIT_LO: begin
        stb.tmrClr = 1'b0;
        if (!initStat)       nxt = S_PROG_SET2;
        else if (timeoutHit) nxt = S_FAIL;
      end
      S_PROG_SET2: begin stb.progSet = 1'b1; nxt = S_WAIT_HI2;  end
      S_WAIT_HI2: begin
        stb.tmrClr = 1'b0;
        if (initStat)        nxt = S_PORT_ON;
        else if (timeoutHit) nxt = S_FAIL;
      end
      S_PORT_ON:   begin stb.portOn = 1'b1; nxt = S_WAIT_DONE; end
      S_WAIT_DONE: begin
        stb.tmrClr = 1'b0;
        if (doneStat)        nxt = S_PORT_OFF;
        else if (timeoutHit) nxt = S_FAIL;
      end
      S_PORT_OFF: begin
        stb.portOff = 1'b1;
        nxt = partQ ? S_FINISH : S_ISO_OPEN;
      end
      S_ISO_OPEN:  begin stb.isoOpen = 1'b1; nxt = S_RST_OFF; end
      S_RST_OFF:   begin stb.rstNone = 1'b1; nxt = S_FINISH;  end
      S_FINISH:    begin stb.okStb   = 1'b1; nxt = S_IDLE;    end
      S_FAIL:      begin stb.errStb  = 1'b1; nxt = S_IDLE;    end
      default:     nxt = S_IDLE;
    endcase
  end

  assign idle = (state == S_IDLE);

  // R10: a busy sequencer only returns to idle through its finish or fail step
  assert_busy_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> (state != S_IDLE) || ($past(state) == S_FINISH) || ($past(state) == S_FAIL));

  // R8: a partial run never enters the reset, isolation or program steps
  assert_partial_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && partialCfg && !(encrypted && !secureBoot)) |=> (state == S_PORT_ON));

endmodule

// File: rtl/plcfg_dpath.sv
module plcfg_dpath
  import plcfg_pkg::*;
#(
  parameter int PRESC_DIV     = 20,
  parameter int TIMEOUT_TICKS = 125000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  seq_strobe_t      stb,
  output logic             timeoutHit,
  output logic [RST_W-1:0] fabricRst,
  output logic [ISO_W-1:0] isoEn,
  output logic             progB,
  output logic             portSel,
  output logic             portMode,
  output logic             rateLow,
  output logic             okPulse,
  output logic             errPulse,
  output err_code_e        errCode
);

  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);
  localparam logic [TW-1:0] TICK_LIMIT = TW'(TIMEOUT_TICKS);

  logic [PW-1:0] prescCnt;
  logic [TW-1:0] tickCnt;

  assign timeoutHit = (tickCnt == TICK_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescCnt <= '0;
      tickCnt  <= '0;
    end else if (stb.tmrClr) begin
      prescCnt <= '0;
      tickCnt  <= '0;
    end else if (!timeoutHit) begin
      if (prescCnt == PRESC_LAST) begin
        prescCnt <= '0;
        tickCnt  <= tickCnt + 1'b1;
      end else begin
        prescCnt <= prescCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fabricRst <= RST_NONE;
      isoEn     <= ISO_BOTH;
      progB     <= 1'b1;
      portSel   <= 1'b0;
      portMode  <= 1'b0;
      rateLow   <= 1'b0;
      okPulse   <= 1'b0;
      errPulse  <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      okPulse  <= stb.okStb;
      errPulse <= stb.errStb;
      if (stb.rstAll)  fabricRst <= RST_ALL;
      if (stb.rstNone) fabricRst <= RST_NONE;
      if (stb.isoOff)  isoEn     <= ISO_NONE;
      if (stb.isoOut)  isoEn     <= ISO_OUTB;
      if (stb.isoOpen) isoEn     <= ISO_BOTH;
      if (stb.progSet) progB     <= 1'b1;
      if (stb.progClr) progB     <= 1'b0;
      if (stb.portOn) begin
        portSel  <= 1'b1;
        portMode <= 1'b1;
        rateLow  <= stb.rateLow;
      end
      if (stb.portOff) portSel <= 1'b0;
      if (stb.okStb)   errCode <= ERR_NONE;
      if (stb.errStb)  errCode <= stb.errCode;
    end
  end

  // R9: result pulses are exclusive and one cycle wide
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(okPulse && errPulse));
  assert_ok_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    okPulse |=> !okPulse);
  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    errPulse |=> !errPulse);

  // R4: the timer never runs past its limit
  assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tickCnt <= TICK_LIMIT);

endmodule

// File: rtl/plcfg_sequencer.sv
module plcfg_sequencer
  import plcfg_pkg::*;
#(
  parameter int PRESC_DIV     = 20,
  parameter int TIMEOUT_TICKS = 125000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             partialCfg,
  input  logic             encrypted,
  input  logic             secureBoot,
  input  logic             initStat,
  input  logic             doneStat,
  output logic [RST_W-1:0] fabricRst,
  output logic [ISO_W-1:0] isoEn,
  output logic             progB,
  output logic             portSel,
  output logic             portMode,
  output logic             rateLow,
  output logic             okPulse,
  output logic             errPulse,
  output logic [1:0]       errCode
);

  seq_strobe_t stb;
  logic        timeoutHit;
  logic        idle;
  err_code_e   errCodeE;

  plcfg_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .partialCfg (partialCfg),
    .encrypted  (encrypted),
    .secureBoot (secureBoot),
    .initStat   (initStat),
    .doneStat   (doneStat),
    .timeoutHit (timeoutHit),
    .stb        (stb),
    .idle       (idle)
  );

  plcfg_dpath #(
    .PRESC_DIV     (PRESC_DIV),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .timeoutHit (timeoutHit),
    .fabricRst  (fabricRst),
    .isoEn      (isoEn),
    .progB      (progB),
    .portSel    (portSel),
    .portMode   (portMode),
    .rateLow    (rateLow),
    .okPulse    (okPulse),
    .errPulse   (errPulse),
    .errCode    (errCodeE)
  );

  assign errCode = errCodeE;

  // R3: the program strobe only falls after init was seen high
  assert_prog_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(progB) |-> $past(initStat));

  // R2: resets and outbound isolation are in place when programming begins
  assert_staged_before_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(progB) |-> (fabricRst == RST_ALL) && (isoEn == ISO_OUTB));

  // R7: the port is released only after done was seen
  assert_release_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(portSel) |-> $past(doneStat));

  // R6: an insecure encrypted start fails with the insecure code
  assert_insecure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && encrypted && !secureBoot) |=> ##1 (errPulse && errCode == 2'd2));

endmodule

// File: tb/plcfg_sequencer_tb.sv
module plcfg_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PRESC      = 4;
  localparam int TICKS      = 10;
  localparam int LIMIT      = PRESC * TICKS;
  localparam int RUN_MAX    = 300;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, partialCfg = 1'b0, encrypted = 1'b0, secureBoot = 1'b0;
  logic initStat, doneStat;
  logic [3:0] fabricRst, isoEn;
  logic progB, portSel, portMode, rateLow, okPulse, errPulse;
  logic [1:0] errCode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // fabric model controls
  logic [1:0] initMode = 2'd0;   // 0 follows strobe, 1 stuck low, 2 stuck high
  logic       doneMode = 1'b0;   // 0 responds, 1 never
  logic [2:0] progDly = 3'b111;
  logic [4:0] selDly  = 5'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    progDly <= {progDly[1:0], progB};
    selDly  <= {selDly[3:0], portSel};
    cyc     <= cyc + 1;
  end

  assign initStat = (initMode == 2'd0) ? progDly[2] : (initMode == 2'd2);
  assign doneStat = !doneMode && selDly[4] && portSel;

  plcfg_sequencer #(.PRESC_DIV(PRESC), .TIMEOUT_TICKS(TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .partialCfg(partialCfg),
    .encrypted(encrypted), .secureBoot(secureBoot), .initStat(initStat),
    .doneStat(doneStat), .fabricRst(fabricRst), .isoEn(isoEn), .progB(progB),
    .portSel(portSel), .portMode(portMode), .rateLow(rateLow),
    .okPulse(okPulse), .errPulse(errPulse), .errCode(errCode)
  );

  typedef struct packed {
    logic       part;
    logic       enc;
    logic       sec;
    logic [1:0] initMode;
    logic       doneMode;
    logic       expOk;
    logic [1:0] expCode;
    logic       expRate;
    logic       expTimeout;
  } scen_t;

  localparam int NSCEN = 8;
  localparam scen_t SCEN [NSCEN] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
    '{0, 0, 0, 2'd1, 0, 0, 2'd1, 0, 1},
    '{0, 0, 0, 2'd0, 1, 0, 2'd1, 0, 1},
    '{1, 1, 1, 2'd0, 1, 0, 2'd1, 0, 1},
    '{0, 0, 0, 2'd2, 0, 0, 2'd1, 0, 1}
  };

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic runScen(input int idx);
    scen_t s = SCEN[idx];
    int tRstF = -1, tIso0 = -1, tIsoA = -1, tProgLo = -1, tProgHi2 = -1;
    int tSel = -1, tSelOff = -1, tIsoF = -1, tRstOff = -1, tPulse = -1;
    int pulses = 0;
    logic touched = 1'b0;
    logic sawOk = 1'b0;
    logic [1:0] code = 2'd0;
    logic rateAtSel = 1'b0, modeAtSel = 1'b0;
    initMode = s.initMode;
    doneMode = s.doneMode;
    doReset();
    partialCfg = s.part; encrypted = s.enc; secureBoot = s.sec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= RUN_MAX && tPulse < 0; c++) begin
      @(negedge clk);
      if (fabricRst != 4'h0 || isoEn != 4'hF || progB != 1'b1) touched = 1'b1;
      if (tRstF < 0 && fabricRst == 4'hF) tRstF = c;
      if (tIso0 < 0 && isoEn == 4'h0) tIso0 = c;
      if (tIsoA < 0 && isoEn == 4'hA) tIsoA = c;
      if (tProgLo < 0 && !progB) tProgLo = c;
      if (tProgLo >= 0 && tProgHi2 < 0 && progB) tProgHi2 = c;
      if (tSel < 0 && portSel) begin tSel = c; rateAtSel = rateLow; modeAtSel = portMode; end
      if (tSel >= 0 && tSelOff < 0 && !portSel) tSelOff = c;
      if (tIsoA >= 0 && tIsoF < 0 && isoEn == 4'hF) tIsoF = c;
      if (tRstF >= 0 && tRstOff < 0 && fabricRst == 4'h0) tRstOff = c;
      if (okPulse || errPulse) begin
        tPulse = c; pulses++; sawOk = okPulse; code = errCode;
      end
    end
    check(tPulse > 0, $sformatf("R9 scen%0d result pulse seen", idx), tPulse, 1);
    check(sawOk == s.expOk, $sformatf("R4/R7 scen%0d outcome ok", idx), sawOk, s.expOk);
    check(code == s.expCode, $sformatf("R4/R6 scen%0d errCode", idx), code, s.expCode);
    @(negedge clk);
    check(!okPulse && !errPulse, $sformatf("R9 scen%0d pulse one cycle", idx), okPulse | errPulse, 0);
    if (s.expOk) begin
      check(tSel > 0 && modeAtSel, $sformatf("R5 scen%0d portSel and portMode", idx), modeAtSel, 1);
      check(rateAtSel == s.expRate, $sformatf("R5 scen%0d rateLow", idx), rateAtSel, s.expRate);
      check(tSelOff > tSel, $sformatf("R7 scen%0d port released", idx), tSelOff, tSel + 1);
    end
    if (s.expOk && !s.part) begin
      check(tRstF > 0 && tRstF < tIso0 && tIso0 < tIsoA && tIsoA < tProgLo,
            $sformatf("R2 scen%0d staging order", idx), tProgLo, tIsoA + 1);
      check(tProgLo < tProgHi2 && tProgHi2 < tSel,
            $sformatf("R3 scen%0d handshake order", idx), tSel, tProgHi2 + 1);
      check(tSelOff < tIsoF && tIsoF < tRstOff && tRstOff < tPulse,
            $sformatf("R7 scen%0d release order", idx), tRstOff, tIsoF + 1);
      check(fabricRst == 4'h0 && isoEn == 4'hF, $sformatf("R7 scen%0d final levels", idx),
            {fabricRst, isoEn}, 8'h0F);
    end
    if (s.part) begin
      check(!touched, $sformatf("R8 scen%0d partial leaves rst/iso/prog", idx), touched, 0);
    end
    if (s.expTimeout) begin
      check(tPulse >= LIMIT && tPulse <= LIMIT + 40,
            $sformatf("R4 scen%0d timeout window", idx), tPulse, LIMIT);
    end
    if (s.expCode == 2'd2) begin
      check(tPulse == 1, $sformatf("R6 scen%0d refusal timing", idx), tPulse, 1);
      check(!touched && !portSel && !portMode, $sformatf("R6 scen%0d nothing changed", idx),
            touched, 0);
    end
  endtask

  initial begin
    doReset();
    // R1: reset state
    check(fabricRst == 4'h0, "R1 fabricRst reset", fabricRst, 0);
    check(isoEn == 4'hF, "R1 isoEn reset", isoEn, 15);
    check(progB == 1'b1, "R1 progB reset", progB, 1);
    check(!portSel && !portMode && !rateLow, "R1 port reset",
          {portSel, portMode, rateLow}, 0);
    check(!okPulse && !errPulse, "R1 pulses reset", {okPulse, errPulse}, 0);

    for (int i = 0; i < NSCEN; i++) runScen(i);

    // R10: a start during a busy run is ignored
    begin
      int oks = 0;
      int errs = 0;
      int afterOk = -1;
      logic disturbed = 1'b0;
      initMode = 2'd0; doneMode = 1'b0;
      doReset();
      partialCfg = 1'b0; encrypted = 1'b0; secureBoot = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= RUN_MAX; c++) begin
        @(negedge clk);
        start = (c == 20);
        if (okPulse) begin oks++; afterOk = c; end
        if (errPulse) errs++;
        if (afterOk > 0 && c > afterOk && (fabricRst != 4'h0 || isoEn != 4'hF || portSel))
          disturbed = 1'b1;
      end
      start = 1'b0;
      check(oks == 1 && errs == 0, "R10 one result for one accepted start", oks, 1);
      check(!disturbed, "R10 no second sequence after ignored start", disturbed, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule